// File: doc/BRIEF.md
# SMRAM Address Decode and Access Guard

This block sits inside a memory controller and classifies every bus cycle as a System Management RAM (SMRAM) access, a normal main-memory access, or a blocked access. It looks at the cycle address, whether the requester is the CPU or another bus master such as a DMA engine, the active-low system-management-active signal, a software-driven manual-open bit, and a mode bit. The manual-open bit lets boot code fill SMRAM before the first management interrupt. The mode bit picks between an overlaid SMRAM that shares an address range with main memory and a separate SMRAM that has its own physical range.

In overlaid mode the shared range defaults to 0x38000 to 0x3FFFF. While management mode is active, a handler still has to reach the main memory hidden under SMRAM, so an alias window at a fixed address is translated onto that hidden range. The decision is made combinationally. It is then registered, so the selects, the denied flag and the translated memory address are valid one clock after the address strobe.

Top module: `smram_guard`

## Requirements
- R1: After synchronous reset, and one cycle after any clock edge with `addr_strobe` low, `out_valid`, `sel_smram`, `sel_main` and `denied` are 0 and `mem_addr` is 0. A strobe sampled at one rising edge gives `out_valid`=1 and its result on the outputs after that edge.
- R2: With `mode_sep`=0, a CPU cycle (`req_cpu`=1) with `smm_act_n`=0 to 0x38000 through 0x3FFFF sets `sel_smram`, and `mem_addr` carries the 15-bit offset into SMRAM, zero-extended.
- R3: With `mode_sep`=0, `smm_act_n`=1 and `man_open`=0, cycles to 0x38000 through 0x3FFFF set `sel_main`, and `mem_addr` equals the address unchanged.
- R4: `man_open`=1 grants a CPU cycle SMRAM access in either mode without management mode being active.
- R5: A cycle with `req_cpu`=0 never sets `sel_smram`. In overlaid mode it goes to main memory.
- R6: With `mode_sep`=1, SMRAM is at 0x0100_0000 through 0x0100_7FFF. A granted CPU cycle there sets `sel_smram` with the offset on `mem_addr`. Any other cycle there sets `denied` only, with `mem_addr`=0. `denied` is never set in overlaid mode.
- R7: With `mode_sep`=1, cycles to 0x38000 through 0x3FFFF go to main memory with the address unchanged.
- R8: With `mode_sep`=0 and `smm_act_n`=0, any master's cycle to the alias window 0x0020_0000 through 0x0020_7FFF sets `sel_main`, and `mem_addr` = 0x38000 + offset. When management mode is inactive, or when `mode_sep`=1, such addresses pass through to main memory unchanged.
- R9: Addresses in no window, including the edges just outside a window, go to main memory unchanged.
- R10: When `out_valid` is 1, exactly one of `sel_smram`, `sel_main` and `denied` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strobe | input | 1 | Cycle valid this clock |
| addr | input | 32 | Cycle address |
| req_cpu | input | 1 | 1 = CPU, 0 = alternate bus master |
| smm_act_n | input | 1 | Management mode active, low true |
| man_open | input | 1 | Manual SMRAM open for initialization |
| mode_sep | input | 1 | 1 = separate SMRAM range, 0 = overlaid |
| out_valid | output | 1 | Registered result valid |
| sel_smram | output | 1 | Route to SMRAM |
| sel_main | output | 1 | Route to main memory |
| denied | output | 1 | Access blocked |
| mem_addr | output | 32 | SMRAM offset or main-memory address |

## Verification
The assertions assume that the control inputs and the address are stable around each rising edge, that the three windows are aligned to their size and do not overlap, and that reset is held for at least one edge before the first strobe. The bench changes every input only on the falling clock edge and reads the results one full cycle later. Its addresses come from inside each window, from the first and last byte of a window, and from just outside a window, so every address it uses has one defined routing outcome.

// File: rtl/smram_pkg.sv
package smram_pkg;
  typedef enum logic [1:0] {
    RT_MAIN  = 2'd0,
    RT_SMRAM = 2'd1,
    RT_DENY  = 2'd2
  } route_e;

  localparam int WIN_OVL   = 0;
  localparam int WIN_SEP   = 1;
  localparam int WIN_ALIAS = 2;
  localparam int WIN_COUNT = 3;
endpackage

// File: rtl/smram_window.sv
module smram_window #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_LOG2 = 15,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 hit,
  output logic [SIZE_LOG2-1:0] offset
);
  localparam int TAG_W = ADDR_W - SIZE_LOG2;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:SIZE_LOG2];

  always_comb begin
    hit    = (addr[ADDR_W-1:SIZE_LOG2] == BASE_TAG);
    offset = addr[SIZE_LOG2-1:0];
  end
endmodule

// File: rtl/smram_route.sv
module smram_route
  import smram_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SIZE_LOG2 = 15,
  parameter logic [ADDR_W-1:0] OVL_BASE = 32'h0003_8000
) (
  input  logic [WIN_COUNT-1:0] hit,
  input  logic [SIZE_LOG2-1:0] off_ovl,
  input  logic [SIZE_LOG2-1:0] off_sep,
  input  logic [SIZE_LOG2-1:0] off_alias,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 req_cpu,
  input  logic                 smm_act_n,
  input  logic                 man_open,
  input  logic                 mode_sep,
  output route_e               route,
  output logic [ADDR_W-1:0]    addr_out
);
  localparam int PAD_W = ADDR_W - SIZE_LOG2;

  logic granted;

  always_comb begin
    granted  = req_cpu & (~smm_act_n | man_open);
    route    = RT_MAIN;
    addr_out = addr;
    if (mode_sep) begin
      if (hit[WIN_SEP]) begin
        if (granted) begin
          route    = RT_SMRAM;
          addr_out = {{PAD_W{1'b0}}, off_sep};
        end else begin
          route    = RT_DENY;
          addr_out = '0;
        end
      end
    end else begin
      if (hit[WIN_OVL] && granted) begin
        route    = RT_SMRAM;
        addr_out = {{PAD_W{1'b0}}, off_ovl};
      end else if (hit[WIN_ALIAS] && !smm_act_n) begin
        addr_out = OVL_BASE | {{PAD_W{1'b0}}, off_alias};
      end
    end
  end
endmodule

// File: rtl/smram_guard.sv
module smram_guard
  import smram_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SIZE_LOG2 = 15,
  parameter logic [ADDR_W-1:0] OVL_BASE   = 32'h0003_8000,
  parameter logic [ADDR_W-1:0] SEP_BASE   = 32'h0100_0000,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h0020_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              req_cpu,
  input  logic              smm_act_n,
  input  logic              man_open,
  input  logic              mode_sep,
  output logic              out_valid,
  output logic              sel_smram,
  output logic              sel_main,
  output logic              denied,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam logic [WIN_COUNT*ADDR_W-1:0] BASES = {ALIAS_BASE, SEP_BASE, OVL_BASE};

  logic [WIN_COUNT-1:0] hit;
  logic [SIZE_LOG2-1:0] offs [WIN_COUNT];
  route_e               route;
  logic [ADDR_W-1:0]    addr_nxt;

  for (genvar i = 0; i < WIN_COUNT; i++) begin : g_win
    smram_window #(
      .ADDR_W   (ADDR_W),
      .SIZE_LOG2(SIZE_LOG2),
      .BASE     (BASES[i*ADDR_W +: ADDR_W])
    ) win_i (
      .addr  (addr),
      .hit   (hit[i]),
      .offset(offs[i])
    );
  end

  smram_route #(
    .ADDR_W   (ADDR_W),
    .SIZE_LOG2(SIZE_LOG2),
    .OVL_BASE (OVL_BASE)
  ) route_i (
    .hit      (hit),
    .off_ovl  (offs[WIN_OVL]),
    .off_sep  (offs[WIN_SEP]),
    .off_alias(offs[WIN_ALIAS]),
    .addr     (addr),
    .req_cpu  (req_cpu),
    .smm_act_n(smm_act_n),
    .man_open (man_open),
    .mode_sep (mode_sep),
    .route    (route),
    .addr_out (addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      sel_smram <= 1'b0;
      sel_main  <= 1'b0;
      denied    <= 1'b0;
      mem_addr  <= '0;
    end else begin
      out_valid <= addr_strobe;
      sel_smram <= addr_strobe && (route == RT_SMRAM);
      sel_main  <= addr_strobe && (route == RT_MAIN);
      denied    <= addr_strobe && (route == RT_DENY);
      mem_addr  <= addr_strobe ? addr_nxt : '0;
    end
  end
endmodule

// File: rtl/smram_guard_chk.sv
module smram_guard_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              addr_strobe,
  input logic              req_cpu,
  input logic              smm_act_n,
  input logic              man_open,
  input logic              mode_sep,
  input logic              out_valid,
  input logic              sel_smram,
  input logic              sel_main,
  input logic              denied,
  input logic [ADDR_W-1:0] mem_addr
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    addr_strobe |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !addr_strobe |=> !sel_smram && !sel_main && !denied && mem_addr == '0); // R1
  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones({sel_smram, sel_main, denied}) == 1); // R10
  AST_ALT_NO_SMRAM: assert property (@(posedge clk) disable iff (rst)
    addr_strobe && !req_cpu |=> !sel_smram); // R5
  AST_OVL_CLOSED: assert property (@(posedge clk) disable iff (rst)
    addr_strobe && !mode_sep && smm_act_n && !man_open |=> sel_main); // R3
  AST_NO_DENY_OVL: assert property (@(posedge clk) disable iff (rst)
    addr_strobe && !mode_sep |=> !denied); // R6
  AST_DENY_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    denied |-> mem_addr == '0); // R6
endmodule

bind smram_guard smram_guard_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .addr_strobe(addr_strobe),
  .req_cpu    (req_cpu),
  .smm_act_n  (smm_act_n),
  .man_open   (man_open),
  .mode_sep   (mode_sep),
  .out_valid  (out_valid),
  .sel_smram  (sel_smram),
  .sel_main   (sel_main),
  .denied     (denied),
  .mem_addr   (mem_addr)
);

// File: tb/smram_guard_tb_top.sv
module smram_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_strobe = 1'b0;
  logic [31:0] addr = '0;
  logic        req_cpu = 1'b0;
  logic        smm_act_n = 1'b1;
  logic        man_open = 1'b0;
  logic        mode_sep = 1'b0;
  logic        out_valid, sel_smram, sel_main, denied;
  logic [31:0] mem_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  smram_guard dut_i (
    .clk(clk), .rst(rst), .addr_strobe(addr_strobe), .addr(addr),
    .req_cpu(req_cpu), .smm_act_n(smm_act_n), .man_open(man_open),
    .mode_sep(mode_sep), .out_valid(out_valid), .sel_smram(sel_smram),
    .sel_main(sel_main), .denied(denied), .mem_addr(mem_addr)
  );

  // entry: addr, cpu, smm_n, open, sep, {smram,main,deny}, expected mem_addr
  localparam int NV = 18;
  localparam logic [70:0] VEC [NV] = '{
    {32'h0003_8000, 4'b1000, 3'b100, 32'h0000_0000}, // R2 first byte
    {32'h0003_FFFF, 4'b1000, 3'b100, 32'h0000_7FFF}, // R2 last byte
    {32'h0003_A123, 4'b1100, 3'b010, 32'h0003_A123}, // R3
    {32'h0003_7FFF, 4'b1000, 3'b010, 32'h0003_7FFF}, // R9 below window
    {32'h0004_0000, 4'b1000, 3'b010, 32'h0004_0000}, // R9 above window
    {32'h0003_A123, 4'b1110, 3'b100, 32'h0000_2123}, // R4 overlaid
    {32'h0003_A123, 4'b0000, 3'b010, 32'h0003_A123}, // R5 in SMM
    {32'h0003_A123, 4'b0110, 3'b010, 32'h0003_A123}, // R5 with open
    {32'h0100_7FFF, 4'b1001, 3'b100, 32'h0000_7FFF}, // R6 granted
    {32'h0100_0010, 4'b1101, 3'b001, 32'h0000_0000}, // R6 cpu ungranted
    {32'h0100_0010, 4'b0001, 3'b001, 32'h0000_0000}, // R6 alternate master
    {32'h0100_0010, 4'b1111, 3'b100, 32'h0000_0010}, // R4 separate
    {32'h0003_A123, 4'b1001, 3'b010, 32'h0003_A123}, // R7
    {32'h0020_1234, 4'b1000, 3'b010, 32'h0003_9234}, // R8 cpu
    {32'h0020_1234, 4'b0000, 3'b010, 32'h0003_9234}, // R8 alternate
    {32'h0020_1234, 4'b1100, 3'b010, 32'h0020_1234}, // R8 outside SMM
    {32'h0020_1234, 4'b1001, 3'b010, 32'h0020_1234}, // R8 separate mode
    {32'h0100_8000, 4'b1001, 3'b010, 32'h0100_8000}  // R9 past sep window
  };
  localparam string VREQ [NV] = '{
    "R2", "R2", "R3", "R9", "R9", "R4", "R5", "R5", "R6",
    "R6", "R6", "R4", "R7", "R8", "R8", "R8", "R8", "R9"
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [70:0] v);
    addr_strobe = 1'b1;
    addr        = v[70:39];
    req_cpu     = v[38];
    smm_act_n   = v[37];
    man_open    = v[36];
    mode_sep    = v[35];
  endtask

  task automatic check_outs(input string req, input logic [2:0] sel, input logic [31:0] ea);
    check(req, {29'd0, sel_smram, sel_main, denied}, {29'd0, sel});
    check(req, mem_addr, ea);
    check("R10", {31'd0, out_valid}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {28'd0, out_valid, sel_smram, sel_main, denied}, 32'd0);
    check("R1", mem_addr, 32'd0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check_outs(VREQ[i], VEC[i][34:32], VEC[i][31:0]);
    end
    // R1: idle strobe clears outputs one cycle later
    addr_strobe = 1'b0;
    @(negedge clk);
    check("R1", {28'd0, out_valid, sel_smram, sel_main, denied}, 32'd0);
    check("R1", mem_addr, 32'd0);
    // R1: back-to-back strobes, result follows each one cycle later
    drive(VEC[0]);
    @(negedge clk);
    drive(VEC[9]);
    check_outs("R1", 3'b100, 32'h0);
    @(negedge clk);
    check_outs("R1", 3'b001, 32'h0);
    // R1: reset during activity clears everything
    drive(VEC[1]);
    rst = 1'b1;
    @(negedge clk);
    check("R1", {28'd0, out_valid, sel_smram, sel_main, denied}, 32'd0);
    check("R1", mem_addr, 32'd0);
    rst = 1'b0;
    addr_strobe = 1'b0;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule